// File: doc/BRIEF.md
# SIMD Load/Store Address Generator

This block forms the memory address for a load or store that moves data between memory and a 64-bit SIMD register. For one request it takes a base register value, the program counter, an 8-bit immediate offset or a shifted register offset, an add/subtract direction, an addressing mode and an access size. It returns the access address and the byte-lane enables for a 64-bit data bus. It also returns the base-register update (an enable and a value), a doubleword misalignment fault and a flag for an illegal register-offset encoding.

Requests enter on a valid/ready handshake, and results leave on a second valid/ready handshake. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs after that edge, with `out_valid` high. While `out_ready` is low, the result stays on the outputs unchanged and `in_ready` is low, so no new request can overwrite it. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. This lets back-to-back requests flow at one per cycle.

Top module: `simd_agu`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Pre-indexed mode (`mode`=1): the address is base plus or minus the offset, `wb_en` is 1 and `wb_val` equals the address.
- R3: Post-indexed mode (`mode`=2): the address is the unmodified base, `wb_en` is 1 and `wb_val` is base plus or minus the offset.
- R4: Zero-offset mode (`mode`=0): the address is the base, `wb_en` is 0 and `wb_val` is the base, whatever the offset inputs hold.
- R5: With `use_reg`=0 the offset is `imm` multiplied by 4 (0 to 1020). `sub`=1 subtracts the offset and `sub`=0 adds it.
- R6: With `use_reg`=1 in pre- or post-indexed mode, the offset is `rm_val` shifted left by `shamt` (0 to 15).
- R7: PC-relative mode (`mode`=3): the address is `pc` plus or minus `imm`*4, so it stays within 1020 bytes of the PC. `use_reg` and `rm_val` are ignored, and `wb_en` is 0.
- R8: `byte_en` bit i enables byte lane i. `size` 0/1/2/3 (byte/halfword/word/doubleword) enables 1/2/4/8 contiguous lanes. The first enabled lane is `addr[2:0]` rounded down to a multiple of the lane count.
- R9: `align_fault` is 1 exactly when `size`=3 and `addr[2:0]` is not zero. It is never 1 for the smaller sizes.
- R10: `invalid` is 1 when `use_reg`=1 and `rm_is_pc`=1 in pre- or post-indexed mode. An invalid request has `wb_en` 0.
- R11: A result is valid on the edge after acceptance. While `out_ready` is 0 it is held stable and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| base | input | 32 | Base register value |
| pc | input | 32 | Program counter for PC-relative mode |
| imm | input | 8 | Immediate offset in words |
| rm_val | input | 32 | Register offset value |
| rm_is_pc | input | 1 | Register offset names the PC |
| shamt | input | 4 | Left shift applied to the register offset |
| use_reg | input | 1 | Use the register offset instead of the immediate |
| sub | input | 1 | Subtract the offset when 1 |
| mode | input | 2 | 0 zero offset, 1 pre-indexed, 2 post-indexed, 3 PC-relative |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| addr | output | 32 | Access address |
| byte_en | output | 8 | Byte-lane enables |
| wb_en | output | 1 | Base-register writeback enable |
| wb_val | output | 32 | Base-register writeback value |
| align_fault | output | 1 | Misaligned doubleword |
| invalid | output | 1 | Illegal register-offset encoding |

## Verification
All results come from one register stage. Every output field is therefore due on the first rising edge after the request is accepted. The bench drives each request on a falling edge, lets one rising edge accept it, and reads the outputs on the next falling edge. The back-pressure scenario holds `out_ready` low over several further edges. On each falling edge it checks that `in_ready` is low and that the earlier result is unchanged. It then releases `out_ready` and checks that `out_valid` clears one edge later.

// File: rtl/simd_agu_pkg.sv
package simd_agu_pkg;
  typedef enum logic [1:0] {
    AM_ZERO  = 2'd0,
    AM_PRE   = 2'd1,
    AM_POST  = 2'd2,
    AM_PCREL = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } asize_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int AW   = 32,
  parameter int IMMW = 8,
  parameter int SHW  = 4
) (
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   rm_val,
  input  logic [SHW-1:0]  shamt,
  input  logic            use_reg,
  output logic [AW-1:0]   off
);
  // immediate counts words: scale by four
  logic [AW-1:0] imm_scaled;
  assign imm_scaled = AW'({imm, 2'b00});

  always_comb begin
    if (use_reg) off = rm_val << shamt;
    else         off = imm_scaled;
  end
endmodule

// File: rtl/agu_addr.sv
module agu_addr
  import simd_agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] off,
  input  logic          sub,
  input  amode_e        mode,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_mode
);
  logic [AW-1:0] anchor;
  logic [AW-1:0] moved;

  assign anchor = (mode == AM_PCREL) ? pc : base;
  assign moved  = sub ? (anchor - off) : (anchor + off);

  always_comb begin
    addr    = base;
    wb_val  = base;
    wb_mode = 1'b0;
    unique case (mode)
      AM_PRE: begin
        addr    = moved;
        wb_val  = moved;
        wb_mode = 1'b1;
      end
      AM_POST: begin
        wb_val  = moved;
        wb_mode = 1'b1;
      end
      AM_PCREL: addr = moved;
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_lanes.sv
module agu_lanes
  import simd_agu_pkg::*;
#(
  parameter int LANES = 8,
  localparam int LOGL = $clog2(LANES)
) (
  input  asize_e           size,
  input  logic [LOGL-1:0]  addr_lo,
  output logic [LANES-1:0] byte_en,
  output logic             fault
);
  logic [LOGL-1:0] start;
  logic [LOGL:0]   nbytes;

  assign nbytes = (LOGL+1)'(1) << size;
  // round the low address down to the access width
  assign start  = addr_lo & ~LOGL'(nbytes - 1'b1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign byte_en[i] = (i >= int'(start)) && (i < int'(start) + int'(nbytes));
  end

  assign fault = (size == SZ_D) && (addr_lo != '0);
endmodule

// File: rtl/simd_agu.sv
module simd_agu
  import simd_agu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMMW  = 8,
  parameter int SHW   = 4,
  parameter int LANES = 8,
  localparam int LOGL = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    pc,
  input  logic [IMMW-1:0]  imm,
  input  logic [AW-1:0]    rm_val,
  input  logic             rm_is_pc,
  input  logic [SHW-1:0]   shamt,
  input  logic             use_reg,
  input  logic             sub,
  input  logic [1:0]       mode,
  input  logic [1:0]       size,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    addr,
  output logic [LANES-1:0] byte_en,
  output logic             wb_en,
  output logic [AW-1:0]    wb_val,
  output logic             align_fault,
  output logic             invalid
);
  amode_e mode_e;
  asize_e size_e;
  assign mode_e = amode_e'(mode);
  assign size_e = asize_e'(size);

  logic indexed;
  logic reg_sel;
  assign indexed = (mode_e == AM_PRE) || (mode_e == AM_POST);
  assign reg_sel = use_reg && indexed;

  logic [AW-1:0] off_c, addr_c, wbv_c;
  logic          wbm_c;
  logic [LANES-1:0] be_c;
  logic          flt_c, inv_c;

  agu_offset #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_off (
    .imm(imm), .rm_val(rm_val), .shamt(shamt), .use_reg(reg_sel), .off(off_c)
  );

  agu_addr #(.AW(AW)) u_addr (
    .base(base), .pc(pc), .off(off_c), .sub(sub), .mode(mode_e),
    .addr(addr_c), .wb_val(wbv_c), .wb_mode(wbm_c)
  );

  agu_lanes #(.LANES(LANES)) u_lanes (
    .size(size_e), .addr_lo(addr_c[LOGL-1:0]), .byte_en(be_c), .fault(flt_c)
  );

  assign inv_c = reg_sel && rm_is_pc;

  logic   accept;
  amode_e mode_q;
  asize_e size_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      addr        <= '0;
      byte_en     <= '0;
      wb_en       <= 1'b0;
      wb_val      <= '0;
      align_fault <= 1'b0;
      invalid     <= 1'b0;
      mode_q      <= AM_ZERO;
      size_q      <= SZ_B;
    end else if (accept) begin
      out_valid   <= 1'b1;
      addr        <= addr_c;
      byte_en     <= be_c;
      wb_en       <= wbm_c && !inv_c;
      wb_val      <= wbv_c;
      align_fault <= flt_c;
      invalid     <= inv_c;
      mode_q      <= mode_e;
      size_q      <= size_e;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(addr) && $stable(byte_en) && $stable(wb_val)); // R11
  AST_WB_NOT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(wb_en && invalid)); // R10
  AST_FAULT_DW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && align_fault |-> size_q == SZ_D); // R9
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(byte_en) == (1 << size_q)); // R8
  AST_WB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wb_en |-> (mode_q == AM_PRE) || (mode_q == AM_POST)); // R7
  AST_PRE_WB_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == AM_PRE |-> wb_val == addr); // R2
  AST_ZERO_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == AM_ZERO |-> addr == wb_val && !wb_en); // R4
endmodule

// File: tb/simd_agu_tb_top.sv
module simd_agu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid = 0, in_ready;
  logic [31:0] base = 0, pc = 0, rm_val = 0;
  logic [7:0]  imm = 0;
  logic        rm_is_pc = 0, use_reg = 0, sub = 0, out_ready = 1;
  logic [3:0]  shamt = 0;
  logic [1:0]  mode = 0, size = 0;
  logic        out_valid, wb_en, align_fault, invalid;
  logic [31:0] addr, wb_val;
  logic [7:0]  byte_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  simd_agu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base(base), .pc(pc), .imm(imm), .rm_val(rm_val), .rm_is_pc(rm_is_pc),
    .shamt(shamt), .use_reg(use_reg), .sub(sub), .mode(mode), .size(size),
    .out_valid(out_valid), .out_ready(out_ready), .addr(addr), .byte_en(byte_en),
    .wb_en(wb_en), .wb_val(wb_val), .align_fault(align_fault), .invalid(invalid)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(input logic [1:0] sz, input logic [2:0] lo);
    int n = 1 << sz;
    int st = (int'(lo) / n) * n;
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (i >= st && i < st + n) r[i] = 1'b1;
    return r;
  endfunction

  // drive one request on a falling edge, accept it on the next rising edge,
  // and leave the bench on the following falling edge where results are due
  task automatic issue(input logic [1:0] m, input logic [1:0] sz, input logic [31:0] b,
                       input logic [7:0] im, input logic ur, input logic [31:0] rv,
                       input logic [3:0] sh, input logic sb, input logic rpc);
    @(negedge clk);
    mode = m; size = sz; base = b; imm = im; use_reg = ur; rm_val = rv;
    shamt = sh; sub = sb; rm_is_pc = rpc; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "out_valid", {31'b0, out_valid}, 32'd0);
    check("R1", "in_ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_pre;
    issue(2'd1, 2'd2, 32'h1000, 8'd5, 1'b0, 0, 0, 1'b0, 1'b0);
    check("R2", "valid", {31'b0, out_valid}, 1);
    check("R2", "addr", addr, 32'h1014);
    check("R2", "wb_en", {31'b0, wb_en}, 1);
    check("R2", "wb_val", wb_val, 32'h1014);
    issue(2'd1, 2'd2, 32'h1000, 8'd255, 1'b0, 0, 0, 1'b1, 1'b0);
    check("R5", "sub max imm", addr, 32'h1000 - 32'd1020);
  endtask

  task automatic t_post;
    issue(2'd2, 2'd2, 32'h2000, 8'd3, 1'b0, 0, 0, 1'b1, 1'b0);
    check("R3", "addr", addr, 32'h2000);
    check("R3", "wb_en", {31'b0, wb_en}, 1);
    check("R3", "wb_val", wb_val, 32'h2000 - 32'd12);
  endtask

  task automatic t_zero;
    issue(2'd0, 2'd2, 32'h3004, 8'd9, 1'b1, 32'h40, 4'd3, 1'b0, 1'b1);
    check("R4", "addr", addr, 32'h3004);
    check("R4", "wb_en", {31'b0, wb_en}, 0);
    check("R4", "wb_val", wb_val, 32'h3004);
    check("R10", "invalid off in zero mode", {31'b0, invalid}, 0);
  endtask

  task automatic t_regoff;
    issue(2'd1, 2'd3, 32'h8000, 8'd0, 1'b1, 32'h1, 4'd15, 1'b0, 1'b0);
    check("R6", "shift 15", addr, 32'h8000 + 32'h8000);
    issue(2'd2, 2'd3, 32'h8000, 8'd7, 1'b1, 32'h10, 4'd0, 1'b1, 1'b0);
    check("R6", "shift 0 sub", wb_val, 32'h8000 - 32'h10);
  endtask

  task automatic t_pcrel;
    pc = 32'h0000_4000;
    issue(2'd3, 2'd3, 32'h9999_0000, 8'd255, 1'b1, 32'h100, 4'd2, 1'b0, 1'b1);
    check("R7", "addr fwd", addr, 32'h4000 + 32'd1020);
    check("R7", "wb_en", {31'b0, wb_en}, 0);
    check("R10", "invalid off in pcrel", {31'b0, invalid}, 0);
    issue(2'd3, 2'd2, 32'h0, 8'd1, 1'b0, 0, 0, 1'b1, 1'b0);
    check("R7", "addr back", addr, 32'h4000 - 32'd4);
  endtask

  task automatic t_lanes;
    for (int sz = 0; sz < 4; sz++) begin
      for (int lo = 0; lo < 8; lo += 3) begin
        issue(2'd0, 2'(sz), 32'h100 + 32'(lo), 0, 1'b0, 0, 0, 1'b0, 1'b0);
        check("R8", "byte_en", {24'b0, byte_en}, {24'b0, exp_be(2'(sz), 3'(lo))});
        check("R9", "fault", {31'b0, align_fault}, {31'b0, (sz == 3) && (lo != 0)});
      end
    end
    issue(2'd1, 2'd3, 32'h200, 8'd1, 1'b0, 0, 0, 1'b0, 1'b0);
    check("R9", "dw +4 misaligned", {31'b0, align_fault}, 1);
  endtask

  task automatic t_invalid;
    issue(2'd1, 2'd2, 32'h500, 0, 1'b1, 32'h8, 4'd1, 1'b0, 1'b1);
    check("R10", "invalid", {31'b0, invalid}, 1);
    check("R10", "wb_en", {31'b0, wb_en}, 0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    @(negedge clk);
    mode = 2'd1; size = 2'd2; base = 32'h700; imm = 8'd2; use_reg = 0; sub = 0;
    rm_is_pc = 0; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    base = 32'hA00;
    held = addr;
    check("R11", "first result", held, 32'h708);
    for (int k = 0; k < 3; k++) begin
      check("R11", "in_ready low", {31'b0, in_ready}, 0);
      @(posedge clk);
      @(negedge clk);
      check("R11", "held addr", addr, held);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11", "drained", {31'b0, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pre();
    t_post();
    t_zero();
    t_regoff();
    t_pcrel();
    t_lanes();
    t_invalid();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule